// File: doc/BRIEF.md
# EEPROM Shadow Loader with Checksum Check

This block keeps a local copy of a 64-word, 16-bit configuration EEPROM. It talks to the memory only through a word-level read/write engine below it, which handles the serial pins. On a load command it fetches every word in ascending address order and stores each one in a flop-based shadow. While it does this it adds the words together modulo 2^16. The image counts as usable only when that sum equals a fixed magic value and a masked signature field in one control word holds the expected code.

Clients ask for words by index. When the cached signature is good, the answer comes from the shadow in the same cycle and no EEPROM traffic is made. When it is not good, the block first runs a full reload and then answers. An index beyond the image always reads as zero. A separate command reads words 0 to 62, computes the value that makes the full image sum to the magic constant, and writes it to word 63. Every write also clears the cached signature word, so the next lookup forces a reload.

Top module: `eeshd_loader`

## Requirements
- R1: A load issues one read per address, from 0 up to 63, in ascending order, with `mem_we` low on every one of them.
- R2: After a load, `csum_err` is 1 exactly when the modulo-2^16 sum of the 64 words differs from 16'hBABA. On such a failure the cached signature word is replaced by the clear value (default 16'h0000), so `img_valid` stays 0.
- R3: After a load whose sum passes, `sig_err` is 1 exactly when (word 10 AND 16'hC000) differs from 16'h4000. `img_valid` is 1 only when both checks pass and the block is idle.
- R4: After reset, `busy`, `img_valid`, `csum_err`, `sig_err`, `mem_req` and `lk_ready` are 0, and the cached signature word holds the clear value.
- R5: A lookup with index below 64 while `img_valid` is 1 gets `lk_ready` in the same cycle, with `lk_data` equal to the shadow word at that index, and no EEPROM access.
- R6: A lookup with index below 64 while the image is invalid starts a full reload. `lk_ready` stays low during the reload. Then `lk_ready` pulses for one cycle, with the shadow word if the image is now valid and zero if it is not.
- R7: A lookup with index 64 or above answers at once with `lk_data` = 0 and never starts a reload, whether the image is valid or not.
- R8: A checksum update reads words 0 to 62 in order, then makes exactly one write to address 63 with data 16'hBABA minus their sum, modulo 2^16.
- R9: When the checksum write completes, the cached signature is cleared, so `img_valid` is 0 afterwards.
- R10: `load_req` and `upd_req` are single-cycle pulses, taken only while `busy` is 0. If both arrive together, the load is done and the update is dropped. Pulses that arrive while busy have no effect.
- R11: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_done` is high. That cycle completes the transfer, and `mem_rdata` is taken in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_req | input | 1 | Pulse: reload the whole image |
| upd_req | input | 1 | Pulse: recompute and write the checksum word |
| lk_req | input | 1 | Lookup request, held until `lk_ready` |
| lk_idx | input | 7 | Lookup word index (64 and above read as zero) |
| lk_ready | output | 1 | Lookup answer valid this cycle |
| lk_data | output | 16 | Lookup answer |
| img_valid | output | 1 | Cached image is idle and passes both checks |
| busy | output | 1 | An operation is in progress |
| csum_err | output | 1 | Last load failed the sum check |
| sig_err | output | 1 | Last load passed the sum but failed the signature |
| mem_req | output | 1 | Word request to the EEPROM engine |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 6 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, taken when `mem_done` is high |
| mem_done | input | 1 | Transfer complete |

## Verification
The images are built so that some pass the sum and carry a good signature, some pass the sum but carry a bad signature, and some fail the sum while still carrying a good signature. This separates the sum check, the masked signature compare and the clearing of the signature on a failed sum. A signature with extra low bits set confirms that only the masked bits count. Lookups are made against valid and invalid caches with indices inside and outside the image, which tells a shadow hit from a forced reload and from the out-of-range zero path. The engine latency is varied so that handshake stalls show up as wrong data or a wrong address order. The update test alters the image without reloading it, then checks the written word and reloads to confirm the fixed image now passes.

// File: rtl/eeshd_pkg.sv
package eeshd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_CHECK  = 3'd2,
    ST_SUMRD  = 3'd3,
    ST_WRITE  = 3'd4,
    ST_LKDONE = 3'd5
  } eeshd_state_e;

endpackage

// File: rtl/eeshd_store.sv
module eeshd_store #(
  parameter int              WORDS     = 64,
  parameter int              DW        = 16,
  parameter int              AW        = 6,
  parameter int              SIG_IDX   = 10,
  parameter logic [DW-1:0]   SIG_MASK  = 16'hC000,
  parameter logic [DW-1:0]   SIG_VALID = 16'h4000,
  parameter logic [DW-1:0]   SIG_CLEAR = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sig_ok
);

  logic [DW-1:0] word_q [WORDS];

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    localparam logic [DW-1:0] RST_V = (gi == SIG_IDX) ? SIG_CLEAR : '0;
    logic          hit;
    logic [DW-1:0] q;

    assign hit = wr_en && (wr_addr == AW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_V;
      end else if (hit) begin
        q <= wr_data;
      end
    end

    assign word_q[gi] = q;
  end

  assign rd_data = word_q[rd_addr];
  assign sig_ok  = (word_q[SIG_IDX] & SIG_MASK) == SIG_VALID;

endmodule

// File: rtl/eeshd_walker.sv
module eeshd_walker #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] idx,
  output logic [DW-1:0] sum
);

  logic [AW-1:0] idx_q, idx_d;
  logic [DW-1:0] sum_q, sum_d;

  always_comb begin
    idx_d = idx_q;
    sum_d = sum_q;
    if (clr) begin
      idx_d = '0;
      sum_d = '0;
    end else if (step) begin
      idx_d = idx_q + AW'(1);
      sum_d = sum_q + din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sum_q <= '0;
    end else begin
      idx_q <= idx_d;
      sum_q <= sum_d;
    end
  end

  assign idx = idx_q;
  assign sum = sum_q;

endmodule

// File: rtl/eeshd_ctrl.sv
module eeshd_ctrl
  import eeshd_pkg::*;
#(
  parameter int            WORDS     = 64,
  parameter int            DW        = 16,
  parameter int            AW        = 6,
  parameter int            SIG_IDX   = 10,
  parameter logic [DW-1:0] MAGIC     = 16'hBABA,
  parameter logic [DW-1:0] SIG_CLEAR = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic          upd_req,
  input  logic          lk_req,
  input  logic          lk_oor,
  input  logic          sig_ok,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] cnt,
  input  logic [DW-1:0] sum,
  output eeshd_state_e  state,
  output logic          walk_clr,
  output logic          walk_step,
  output logic          st_we,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          lk_ready,
  output logic          lk_serve,
  output logic          busy,
  output logic          csum_err,
  output logic          sig_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  localparam logic [AW-1:0] LAST_LOAD = AW'(WORDS - 1);
  localparam logic [AW-1:0] LAST_SUM  = AW'(WORDS - 2);
  localparam logic [AW-1:0] SIG_A     = AW'(SIG_IDX);

  eeshd_state_e state_q, state_d;
  logic         from_lk_q, from_lk_d;
  logic         csum_err_q, csum_err_d;
  logic         sig_err_q, sig_err_d;
  logic         idle_free;
  logic         sum_pass;

  assign idle_free = (state_q == ST_IDLE) && !load_req && !upd_req;
  assign sum_pass  = (sum == MAGIC);

  always_comb begin
    state_d    = state_q;
    from_lk_d  = from_lk_q;
    csum_err_d = csum_err_q;
    sig_err_d  = sig_err_q;
    walk_clr   = 1'b0;
    walk_step  = 1'b0;
    st_we      = 1'b0;
    st_addr    = cnt;
    st_data    = mem_rdata;
    unique case (state_q)
      ST_IDLE: begin
        if (load_req) begin
          state_d   = ST_LOAD;
          from_lk_d = 1'b0;
          walk_clr  = 1'b1;
        end else if (upd_req) begin
          state_d  = ST_SUMRD;
          walk_clr = 1'b1;
        end else if (lk_req && !lk_oor && !sig_ok) begin
          state_d   = ST_LOAD;
          from_lk_d = 1'b1;
          walk_clr  = 1'b1;
        end
      end
      ST_LOAD: begin
        if (mem_done) begin
          walk_step = 1'b1;
          st_we     = 1'b1;
          if (cnt == LAST_LOAD) begin
            state_d = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        csum_err_d = !sum_pass;
        sig_err_d  = sum_pass && !sig_ok;
        if (!sum_pass) begin
          st_we   = 1'b1;
          st_addr = SIG_A;
          st_data = SIG_CLEAR;
        end
        state_d = from_lk_q ? ST_LKDONE : ST_IDLE;
      end
      ST_SUMRD: begin
        if (mem_done) begin
          walk_step = 1'b1;
          if (cnt == LAST_SUM) begin
            state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (mem_done) begin
          st_we   = 1'b1;
          st_addr = SIG_A;
          st_data = SIG_CLEAR;
          state_d = ST_IDLE;
        end
      end
      ST_LKDONE: begin
        from_lk_d = 1'b0;
        state_d   = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      from_lk_q  <= 1'b0;
      csum_err_q <= 1'b0;
      sig_err_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      from_lk_q  <= from_lk_d;
      csum_err_q <= csum_err_d;
      sig_err_q  <= sig_err_d;
    end
  end

  always_comb begin
    lk_ready = 1'b0;
    if (state_q == ST_LKDONE) begin
      lk_ready = 1'b1;
    end else if (idle_free && lk_req && (lk_oor || sig_ok)) begin
      lk_ready = 1'b1;
    end
  end

  assign lk_serve  = lk_ready && !lk_oor && sig_ok;
  assign state     = state_q;
  assign busy      = (state_q != ST_IDLE);
  assign csum_err  = csum_err_q;
  assign sig_err   = sig_err_q;
  assign mem_req   = (state_q == ST_LOAD) || (state_q == ST_SUMRD) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_WRITE) ? LAST_LOAD : cnt;
  assign mem_wdata = (state_q == ST_WRITE) ? (MAGIC - sum) : '0;

endmodule

// File: rtl/eeshd_loader.sv
module eeshd_loader
  import eeshd_pkg::*;
#(
  parameter int            WORDS     = 64,
  parameter int            DW        = 16,
  parameter logic [DW-1:0] MAGIC     = 16'hBABA,
  parameter int            SIG_IDX   = 10,
  parameter logic [DW-1:0] SIG_MASK  = 16'hC000,
  parameter logic [DW-1:0] SIG_VALID = 16'h4000,
  parameter logic [DW-1:0] SIG_CLEAR = 16'h0000,
  localparam int           AW        = $clog2(WORDS),
  localparam int           IW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic          upd_req,
  input  logic          lk_req,
  input  logic [IW-1:0] lk_idx,
  output logic          lk_ready,
  output logic [DW-1:0] lk_data,
  output logic          img_valid,
  output logic          busy,
  output logic          csum_err,
  output logic          sig_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done
);

  logic [1:0]    rst_sync_q;
  logic          rst_q;
  eeshd_state_e  state;
  logic          walk_clr, walk_step;
  logic [AW-1:0] cnt;
  logic [DW-1:0] sum;
  logic          st_we;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic [DW-1:0] st_rd;
  logic          sig_ok;
  logic          lk_oor;
  logic          lk_serve;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q = rst_sync_q[1];

  assign lk_oor = (lk_idx >= IW'(WORDS));

  eeshd_store #(
    .WORDS(WORDS), .DW(DW), .AW(AW), .SIG_IDX(SIG_IDX),
    .SIG_MASK(SIG_MASK), .SIG_VALID(SIG_VALID), .SIG_CLEAR(SIG_CLEAR)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_en  (st_we),
    .wr_addr(st_addr),
    .wr_data(st_data),
    .rd_addr(lk_idx[AW-1:0]),
    .rd_data(st_rd),
    .sig_ok (sig_ok)
  );

  eeshd_walker #(.DW(DW), .AW(AW)) u_walker (
    .clk  (clk),
    .rst_n(rst_q),
    .clr  (walk_clr),
    .step (walk_step),
    .din  (mem_rdata),
    .idx  (cnt),
    .sum  (sum)
  );

  eeshd_ctrl #(
    .WORDS(WORDS), .DW(DW), .AW(AW), .SIG_IDX(SIG_IDX),
    .MAGIC(MAGIC), .SIG_CLEAR(SIG_CLEAR)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q),
    .load_req (load_req),
    .upd_req  (upd_req),
    .lk_req   (lk_req),
    .lk_oor   (lk_oor),
    .sig_ok   (sig_ok),
    .mem_done (mem_done),
    .mem_rdata(mem_rdata),
    .cnt      (cnt),
    .sum      (sum),
    .state    (state),
    .walk_clr (walk_clr),
    .walk_step(walk_step),
    .st_we    (st_we),
    .st_addr  (st_addr),
    .st_data  (st_data),
    .lk_ready (lk_ready),
    .lk_serve (lk_serve),
    .busy     (busy),
    .csum_err (csum_err),
    .sig_err  (sig_err),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  assign lk_data   = lk_serve ? st_rd : '0;
  assign img_valid = !busy && sig_ok;

endmodule

// File: rtl/eeshd_loader_chk.sv
module eeshd_loader_chk
  import eeshd_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW    = 16,
  parameter int AW    = 6,
  parameter int IW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input eeshd_state_e  state,
  input logic          lk_ready,
  input logic [IW-1:0] lk_idx,
  input logic [DW-1:0] lk_data,
  input logic          img_valid,
  input logic          csum_err,
  input logic          sig_err,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_done
);

  AST_LOAD_RDONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD || state == ST_SUMRD) |-> !mem_we); // R1

  AST_LOAD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && mem_req && mem_done && mem_addr != AW'(WORDS - 1))
      |=> (mem_addr == $past(mem_addr) + AW'(1))); // R1

  AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    img_valid |-> (!csum_err && !sig_err)); // R3

  AST_NO_READY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !lk_ready); // R6

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ready && lk_idx >= IW'(WORDS)) |-> (lk_data == '0)); // R7

  AST_WR_TOP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == AW'(WORDS - 1))); // R8

  AST_WR_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE && mem_done) |=> !img_valid); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata))); // R11

endmodule

bind eeshd_loader eeshd_loader_chk #(
  .WORDS(WORDS), .DW(DW), .AW(AW), .IW(IW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .state    (state),
  .lk_ready (lk_ready),
  .lk_idx   (lk_idx),
  .lk_data  (lk_data),
  .img_valid(img_valid),
  .csum_err (csum_err),
  .sig_err  (sig_err),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_done (mem_done)
);

// File: tb/eeshd_loader_tb_top.sv
module eeshd_loader_tb_top;

  localparam int          WORDS = 64;
  localparam int          DW    = 16;
  localparam int          AW    = 6;
  localparam int          IW    = 7;
  localparam logic [15:0] MAGIC = 16'hBABA;

  // vector: {fix_checksum, signature word, seed}
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 16'h4000, 16'h0001},
    {1'b1, 16'h7ABC, 16'h0002},
    {1'b1, 16'hC000, 16'h0003},
    {1'b0, 16'h4000, 16'h0004},
    {1'b1, 16'h0000, 16'h0005},
    {1'b1, 16'h4123, 16'h0006}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_req, upd_req, lk_req;
  logic [IW-1:0] lk_idx;
  logic          lk_ready;
  logic [DW-1:0] lk_data;
  logic          img_valid, busy, csum_err, sig_err;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_done;

  logic [15:0] img [WORDS];
  int          lat;
  int          rd_cnt, wr_cnt, bad_order, wait_q;
  logic [5:0]  exp_rd, last_wa;
  logic [15:0] last_wd;
  int          n_chk, n_fail, cyc;
  bit          finished;

  always #5 clk = ~clk;

  eeshd_loader dut_i (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .upd_req(upd_req),
    .lk_req(lk_req), .lk_idx(lk_idx), .lk_ready(lk_ready), .lk_data(lk_data),
    .img_valid(img_valid), .busy(busy), .csum_err(csum_err), .sig_err(sig_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  // word engine model with programmable latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_done <= 1'b0; mem_rdata <= '0; wait_q <= 0; exp_rd <= '0;
      rd_cnt <= 0; wr_cnt <= 0; bad_order <= 0; last_wa <= '0; last_wd <= '0;
    end else if (mem_done) begin
      mem_done <= 1'b0;
    end else if (mem_req) begin
      if (wait_q >= lat) begin
        wait_q   <= 0;
        mem_done <= 1'b1;
        if (mem_we) begin
          wr_cnt  <= wr_cnt + 1;
          last_wa <= mem_addr;
          last_wd <= mem_wdata;
          exp_rd  <= '0;
        end else begin
          mem_rdata <= img[mem_addr];
          rd_cnt    <= rd_cnt + 1;
          if (mem_addr != exp_rd) bad_order <= bad_order + 1;
          exp_rd <= mem_addr + 6'd1;
        end
      end else begin
        wait_q <= wait_q + 1;
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", rq, got, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(input int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + img[i];
    return s;
  endfunction

  task automatic fill(input logic [15:0] seed, input logic [15:0] sig, input bit fix);
    for (int i = 0; i < WORDS; i++) begin
      img[i] = 16'(seed * 16'h1357 + 16'(i) * 16'h0F0F) ^ 16'(i << 9);
    end
    img[10] = sig;
    if (fix) img[63] = MAGIC - sum_to(62);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic pulse(input bit ld, input bit up);
    @(negedge clk);
    load_req = ld; upd_req = up;
    @(negedge clk);
    load_req = 1'b0; upd_req = 1'b0;
  endtask

  task automatic lookup(input logic [IW-1:0] idx, output logic [15:0] data, output int waited);
    @(negedge clk);
    lk_req = 1'b1; lk_idx = idx;
    #1;
    waited = 0;
    while (!lk_ready) begin
      @(negedge clk); #1;
      waited++;
    end
    data = lk_data;
    lk_req = 1'b0;
  endtask

  initial begin
    logic [15:0] d, s, wexp;
    int w, r0, w0;
    bit ce, se;
    n_chk = 0; n_fail = 0; cyc = 0; finished = 0; lat = 1;
    load_req = 0; upd_req = 0; lk_req = 0; lk_idx = '0;
    fill(16'h0009, 16'h4000, 1'b1);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 reset state
    chk(!busy && !img_valid && !csum_err && !sig_err && !mem_req && !lk_ready,
        "R4 reset outputs", {busy, img_valid, csum_err, sig_err, mem_req}, 0);

    // R7 out-of-range while invalid: immediate zero, no reload
    r0 = rd_cnt;
    lookup(7'd64, d, w);
    chk(w == 0 && d == 0, "R7 idx 64 invalid", {d, 16'(w)}, 0);
    lookup(7'd127, d, w);
    repeat (3) @(negedge clk);
    chk(d == 0 && rd_cnt == r0 && !busy, "R7 idx 127 no reload", rd_cnt - r0, 0);

    // R6 invalid lookup forces reload then serves
    r0 = rd_cnt;
    lookup(7'd5, d, w);
    chk(w > 64 && d == img[5], "R6 reload then serve", d, img[5]);
    chk(rd_cnt - r0 == 64 && bad_order == 0, "R1 full ascending reload", rd_cnt - r0, 64);
    @(negedge clk);
    chk(img_valid, "R3 valid after good image", img_valid, 1);

    // R5 valid lookup served from shadow
    r0 = rd_cnt;
    lookup(7'd63, d, w);
    chk(w == 0 && d == img[63], "R5 shadow hit word 63", d, img[63]);
    lookup(7'd100, d, w);
    repeat (3) @(negedge clk);
    chk(d == 0 && rd_cnt == r0, "R7 idx 100 valid", d, 0);

    // vector table walk: R1 R2 R3 R11 under varying latency
    for (int vi = 0; vi < 6; vi++) begin
      lat = vi % 3;
      fill(VEC[vi][15:0], VEC[vi][31:16], VEC[vi][32]);
      s  = sum_to(63);
      ce = (s != MAGIC);
      se = !ce && ((img[10] & 16'hC000) != 16'h4000);
      r0 = rd_cnt;
      pulse(1'b1, 1'b0);
      wait_idle();
      chk(rd_cnt - r0 == 64 && bad_order == 0, "R1 load order", rd_cnt - r0, 64);
      chk(csum_err == ce, "R2 checksum flag", csum_err, ce);
      chk(sig_err == se && img_valid == (!ce && !se), "R3 signature flag",
          {sig_err, img_valid}, {se, !ce && !se});
      if (!ce && !se) begin
        lookup(7'(vi * 11), d, w);
        chk(w == 0 && d == img[vi * 11], "R11 data through handshake", d, img[vi * 11]);
      end else begin
        r0 = rd_cnt;
        lookup(7'd10, d, w);
        chk(d == 0 && rd_cnt - r0 == 64, "R6 still invalid returns zero", d, 0);
      end
    end

    // R8 R9 checksum update
    lat = 2;
    fill(16'h0011, 16'h4000, 1'b1);
    pulse(1'b1, 1'b0);
    wait_idle();
    chk(img_valid, "R3 valid before update", img_valid, 1);
    fill(16'h0021, 16'h4000, 1'b0);
    wexp = MAGIC - sum_to(62);
    r0 = rd_cnt; w0 = wr_cnt;
    pulse(1'b0, 1'b1);
    wait_idle();
    chk(wr_cnt - w0 == 1 && last_wa == 6'd63 && last_wd == wexp, "R8 checksum write",
        {last_wa, last_wd}, {6'd63, wexp});
    chk(rd_cnt - r0 == 63 && bad_order == 0, "R8 reads 0..62", rd_cnt - r0, 63);
    chk(!img_valid, "R9 write invalidates", img_valid, 0);
    img[63] = last_wd;
    pulse(1'b1, 1'b0);
    wait_idle();
    chk(!csum_err && img_valid, "R8 fixed image passes", {csum_err, img_valid}, 1);

    // R10 commands while busy and together
    w0 = wr_cnt; r0 = rd_cnt;
    pulse(1'b1, 1'b0);
    upd_req = 1'b1; load_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0; load_req = 1'b0;
    wait_idle();
    chk(wr_cnt == w0 && rd_cnt - r0 == 64, "R10 busy pulses ignored", wr_cnt - w0, 0);
    r0 = rd_cnt;
    pulse(1'b1, 1'b1);
    wait_idle();
    chk(wr_cnt == w0 && rd_cnt - r0 == 64, "R10 load wins over update", wr_cnt - w0, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule